// File: doc/BRIEF.md
# Frame Difference Threshold Binarizer

This block turns a pair of grayscale frames, the live image and a stored background, into a one-bit motion mask. Each incoming pixel pair gives a difference magnitude. The upstream source streams the whole frame twice. During the first sweep the block only records the largest magnitude it sees. After the frame-end pulse it uses that peak to set a per-frame threshold. During the second sweep, in which the same pairs are sent again, each magnitude above the threshold becomes a 1 and every other one becomes a 0.

The mask bits are packed into words. The leftmost pixel of a run goes in bit 0. A word is emitted when it holds a full set of bits or when the row ends, whichever comes first. Unused high bits of a short word are zero. Output words travel on a valid/ready stream. While a word waits for the consumer, no new pixel is accepted.

A start pulse clears the peak, drops any partial or pending word, and opens the first sweep from any state. A frame-end pulse moves the block from the first sweep to the second, and from the second sweep back to idle.

Top module: `fdiff_binarizer`

## Requirements
- R1: After reset the block is idle, with `inReady` = 0 and `outValid` = 0.
- R2: A `startPulse` clears the recorded peak to 0 and enters the first sweep. During the first sweep `inReady` = 1 on every cycle. A peak left over from an earlier or aborted sweep has no effect on the next frame's mask.
- R3: The magnitude of a pair is |current − background|. A background brighter than the current pixel gives a positive magnitude in the same way as the reverse case.
- R4: The first sweep produces no output words (`outValid` stays 0). The threshold used in the second sweep comes from the peak magnitude over every pair accepted in the first sweep.
- R5: A mask bit is 1 exactly when 256·d > 77·peak, where d is the pair's magnitude. Equality and anything below it give 0. For example, with peak 100, d = 30 gives 0 and d = 31 gives 1.
- R6: Mask bits fill a word from bit 0 upward in arrival order. After 32 bits the word is emitted.
- R7: A pair flagged `inRowLast` closes the current word. The word is emitted the next cycle, with all bit positions above the last filled one set to 0.
- R8: While `outValid` = 1 and `outReady` = 0, `outWord` holds its value and `outValid` stays high. `inReady` is 0 whenever `outValid` = 1.
- R9: A `frameEnd` pulse during the second sweep returns the block to idle (`inReady` = 0).
- R10: When the peak is 0 (every pair equal), every mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Begin a new frame: clear the peak and enter the first sweep |
| frameEnd | input | 1 | End the current sweep |
| inValid | input | 1 | Pixel pair present |
| inReady | output | 1 | Pixel pair accepted when high together with inValid |
| curPix | input | 8 | Current-frame pixel |
| bgPix | input | 8 | Background pixel at the same position |
| inRowLast | input | 1 | Pair is the last of its row |
| outValid | output | 1 | Packed mask word available |
| outReady | input | 1 | Consumer takes the word |
| outWord | output | 32 | Packed mask word, leftmost pixel in bit 0 |

## Verification
The bound checker checks the handshake rules on every cycle. These are: ready is held high in the first sweep, input is closed while idle or while a word waits, a pending word stays fixed under backpressure, no output appears in the first sweep, and a row-end pair always produces a word. Only the bench's scenarios can show whether the mask bits are right. This covers the threshold boundary at exactly 77·peak/256, absolute differences in both directions, bit order and zero padding, the all-equal frame, and the peak being cleared by a restart. The bench checks these against a behavioural model of both sweeps.

// File: rtl/fdb_pkg.sv
package fdb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAX  = 2'd1,
    ST_BIN  = 2'd2
  } fdbState_e;

  typedef struct packed {
    logic clrAll;     // restart: clear peak, packer and output
    logic updMax;     // first-sweep pair accepted
    logic packBit;    // second-sweep pair accepted
    logic flushWord;  // emit the word holding this bit
  } fdbStrobe_t;
endpackage

// File: rtl/fdb_ctrl.sv
module fdb_ctrl
  import fdb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       frameEnd,
  input  logic       inValid,
  input  logic       inRowLast,
  input  logic       wordPending,
  input  logic       wordLast,
  output logic       inReady,
  output fdbState_e  stateNow,
  output fdbStrobe_t strobes
);
  fdbState_e stateReg;
  logic      accept;

  assign stateNow = stateReg;
  assign inReady  = (stateReg == ST_MAX) || ((stateReg == ST_BIN) && !wordPending);
  assign accept   = inValid && inReady && !startPulse;

  always_comb begin
    strobes           = '0;
    strobes.clrAll    = startPulse;
    strobes.updMax    = accept && (stateReg == ST_MAX);
    strobes.packBit   = accept && (stateReg == ST_BIN);
    strobes.flushWord = strobes.packBit && (inRowLast || wordLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateReg <= ST_IDLE;
    end else if (startPulse) begin
      stateReg <= ST_MAX;
    end else if (frameEnd) begin
      case (stateReg)
        ST_MAX:  stateReg <= ST_BIN;
        ST_BIN:  stateReg <= ST_IDLE;
        default: stateReg <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fdb_datapath.sv
module fdb_datapath
  import fdb_pkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int WORD_W     = 32,
  parameter int FRAC_NUM   = 77,
  parameter int FRAC_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fdbStrobe_t        strobes,
  input  logic [PIX_W-1:0]  curPix,
  input  logic [PIX_W-1:0]  bgPix,
  input  logic              outReady,
  output logic              outValid,
  output logic [WORD_W-1:0] outWord,
  output logic              wordLast
);
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int PROD_W = PIX_W + FRAC_SHIFT;

  logic [PIX_W-1:0]  diffMag;
  logic [PIX_W-1:0]  peakReg;
  logic [PROD_W-1:0] scaledDiff;
  logic [PROD_W-1:0] scaledPeak;
  logic              pixBit;
  logic [WORD_W-1:0] accum;
  logic [WORD_W-1:0] nextAccum;
  logic [IDX_W-1:0]  bitIdx;

  assign diffMag    = (curPix >= bgPix) ? (curPix - bgPix) : (bgPix - curPix);
  assign scaledDiff = {diffMag, {FRAC_SHIFT{1'b0}}};
  assign scaledPeak = PROD_W'(peakReg) * PROD_W'(FRAC_NUM);
  assign pixBit     = scaledDiff > scaledPeak;
  assign wordLast   = bitIdx == IDX_W'(WORD_W - 1);

  for (genvar gi = 0; gi < WORD_W; gi++) begin : g_insert
    assign nextAccum[gi] = (bitIdx == IDX_W'(gi)) ? pixBit : accum[gi];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      peakReg <= '0;
    end else if (strobes.clrAll) begin
      peakReg <= '0;
    end else if (strobes.updMax && (diffMag > peakReg)) begin
      peakReg <= diffMag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accum    <= '0;
      bitIdx   <= '0;
      outValid <= 1'b0;
      outWord  <= '0;
    end else if (strobes.clrAll) begin
      accum    <= '0;
      bitIdx   <= '0;
      outValid <= 1'b0;
    end else begin
      if (outValid && outReady) outValid <= 1'b0;
      if (strobes.packBit) begin
        if (strobes.flushWord) begin
          outWord  <= nextAccum;
          outValid <= 1'b1;
          accum    <= '0;
          bitIdx   <= '0;
        end else begin
          accum  <= nextAccum;
          bitIdx <= bitIdx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fdiff_binarizer.sv
module fdiff_binarizer
  import fdb_pkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int WORD_W     = 32,
  parameter int FRAC_NUM   = 77,
  parameter int FRAC_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              frameEnd,
  input  logic              inValid,
  output logic              inReady,
  input  logic [PIX_W-1:0]  curPix,
  input  logic [PIX_W-1:0]  bgPix,
  input  logic              inRowLast,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outWord
);
  fdbStrobe_t strobes;
  fdbState_e  stateNow;
  logic       wordLast;

  fdb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .frameEnd(frameEnd),
    .inValid(inValid), .inRowLast(inRowLast), .wordPending(outValid),
    .wordLast(wordLast), .inReady(inReady), .stateNow(stateNow), .strobes(strobes)
  );

  fdb_datapath #(
    .PIX_W(PIX_W), .WORD_W(WORD_W), .FRAC_NUM(FRAC_NUM), .FRAC_SHIFT(FRAC_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curPix(curPix), .bgPix(bgPix),
    .outReady(outReady), .outValid(outValid), .outWord(outWord), .wordLast(wordLast)
  );
endmodule

// File: rtl/fdb_checker.sv
module fdb_checker
  import fdb_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              inValid,
  input logic              inReady,
  input logic              inRowLast,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outWord,
  input fdbState_e         stateNow
);
  a_r2_ready_in_max: assert property (@(posedge clk) disable iff (!rstN)
    (stateNow == ST_MAX) |-> inReady);

  a_r4_quiet_in_max: assert property (@(posedge clk) disable iff (!rstN)
    (stateNow == ST_MAX) |-> !outValid);

  a_r7_row_flush: assert property (@(posedge clk) disable iff (!rstN)
    ((stateNow == ST_BIN) && inValid && inReady && inRowLast && !startPulse) |=> outValid);

  a_r8_hold_word: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !startPulse) |=> (outValid && $stable(outWord)));

  a_r8_stall_input: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  a_r9_idle_closed: assert property (@(posedge clk) disable iff (!rstN)
    (stateNow == ST_IDLE) |-> !inReady);
endmodule

bind fdiff_binarizer fdb_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .inValid(inValid),
  .inReady(inReady), .inRowLast(inRowLast), .outValid(outValid),
  .outReady(outReady), .outWord(outWord), .stateNow(stateNow)
);

// File: tb/sim_fdiff_binarizer.sv
`timescale 1ns/1ps
module sim_fdiff_binarizer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0, frameEnd = 1'b0;
  logic        inValid = 1'b0, inRowLast = 1'b0, outReady = 1'b1;
  logic [7:0]  curPix = '0, bgPix = '0;
  logic        inReady, outValid;
  logic [31:0] outWord;

  int passCnt = 0, totalCnt = 0;
  logic [31:0] expQ[$];
  int cq[$], bq[$];
  int nRows, nCols, cyc = 0;
  bit stallOn = 0, inMax = 0, holding = 0, done = 0;
  logic [31:0] heldWord;
  string curTag = "R1";

  always #2 clk = ~clk;

  fdiff_binarizer u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .frameEnd(frameEnd),
    .inValid(inValid), .inReady(inReady), .curPix(curPix), .bgPix(bgPix),
    .inRowLast(inRowLast), .outValid(outValid), .outReady(outReady), .outWord(outWord)
  );

  task automatic check(bit ok, string tag, longint act, longint exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1 outReady = stallOn ? ((cyc % 3) != 0) : 1'b1;
  end

  // Reference comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (inMax) check(!outValid, "R4 no output in first sweep", outValid, 0);
      if (outValid) begin
        if (holding) check(outWord == heldWord, "R8 held word", outWord, heldWord);
        if (outReady) begin
          if (expQ.size() == 0) check(0, {curTag, " unexpected word"}, outWord, 0);
          else begin
            logic [31:0] e;
            e = expQ.pop_front();
            check(outWord == e, curTag, outWord, e);
          end
          holding = 0;
        end else begin
          holding = 1;
          heldWord = outWord;
        end
      end else holding = 0;
    end
  end

  function automatic int absd(int a, int b);
    return (a >= b) ? a - b : b - a;
  endfunction

  task automatic buildFrame(int kind, int rows, int cols);
    cq.delete(); bq.delete(); nRows = rows; nCols = cols;
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++) begin
        int cv, bv;
        case (kind)
          0: begin cv = (r*37 + c*11) % 256; bv = (r*53 + c*29 + 7) % 256; end
          1: begin
               if (c == 0) begin cv = 100; bv = 0; end
               else if (c % 2 == 1) begin cv = 10; bv = 40; end
               else begin cv = 71; bv = 40; end
             end
          2: begin cv = (c*7 + r) % 256; bv = cv; end
          default: begin cv = (r*91 + c*13 + 5) % 256; bv = (c*17 + 200) % 256; end
        endcase
        cq.push_back(cv); bq.push_back(bv);
      end
  endtask

  task automatic computeExpected();
    int peak = 0;
    foreach (cq[i]) if (absd(cq[i], bq[i]) > peak) peak = absd(cq[i], bq[i]);
    for (int r = 0; r < nRows; r++) begin
      logic [31:0] w = '0;
      int n = 0;
      for (int c = 0; c < nCols; c++) begin
        int d = absd(cq[r*nCols+c], bq[r*nCols+c]);
        w[n] = (d*256 > peak*77);
        n++;
        if (n == 32 || c == nCols-1) begin
          expQ.push_back(w); w = '0; n = 0;
        end
      end
    end
  endtask

  task automatic sendPix(int c, int b, bit last);
    @(negedge clk);
    curPix = 8'(c); bgPix = 8'(b); inRowLast = last; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1 inValid = 1'b0; inRowLast = 1'b0;
  endtask

  task automatic sendAll();
    foreach (cq[i]) sendPix(cq[i], bq[i], ((i % nCols) == nCols-1));
  endtask

  task automatic pulse(bit isStart);
    @(negedge clk);
    if (isStart) startPulse = 1'b1; else frameEnd = 1'b1;
    @(negedge clk);
    startPulse = 1'b0; frameEnd = 1'b0;
  endtask

  task automatic runFrame(int kind, int rows, int cols, string tag);
    buildFrame(kind, rows, cols);
    curTag = tag;
    pulse(1);
    check(inReady == 1'b1, "R2 ready in first sweep", inReady, 1);
    inMax = 1;
    sendAll();
    @(negedge clk); inMax = 0;
    pulse(0);
    computeExpected();
    sendAll();
    for (int k = 0; k < 2000 && expQ.size() != 0; k++) @(negedge clk);
    check(expQ.size() == 0, {tag, " words outstanding"}, expQ.size(), 0);
    pulse(0);
    @(negedge clk);
    check(inReady == 1'b0, "R9 idle after second frameEnd", inReady, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(inReady == 1'b0 && outValid == 1'b0, "R1 reset state", {inReady, outValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b0 && outValid == 1'b0, "R1 idle after reset", {inReady, outValid}, 0);
    runFrame(0, 2, 40, "R5 R6 R7 mixed frame");
    runFrame(1, 1, 32, "R3 R5 R6 threshold boundary");
    // aborted first sweep with a large peak, then a restart
    pulse(1);
    for (int i = 0; i < 4; i++) sendPix(255, 0, 0);
    runFrame(1, 1, 32, "R2 peak cleared on restart");
    runFrame(2, 2, 20, "R10 zero peak");
    stallOn = 1;
    runFrame(3, 3, 64, "R8 backpressure");
    stallOn = 0;
    runFrame(0, 1, 5, "R7 short row");
    finishRun();
  end
endmodule